// File: doc/BRIEF.md
# Special Bus Cycle Decoder and Acknowledger

This block sits in system logic next to a processor bus whose control lines are active low. On each rising clock edge where the address strobe is low, it looks at the three cycle-type qualifiers. If they mark a special cycle, it latches the byte enables and the address. On the following clock it decodes them into one of seven processor events. It then presents a one-clock event strobe together with a 3-bit event code. In that same clock it drives the ready line low so the processor can end the cycle.

Every special cycle is acknowledged. This holds even when its encoding is unknown or its upper address bits are not zero. Such cycles raise a one-clock error flag instead of an event code. One byte-enable value stands for two different events, and address bit 4 tells them apart. Memory and I/O cycles get no response from this block. An address strobe that arrives while a special cycle is still being handled is ignored.

Top module: `sbc_responder`

## Requirements
- R1: While reset (synchronous, active high) is held, and on the first clock after it is released, readyN is high and evtValid, evtErr and evtCode are all 0.
- R2: A strobe sampled low counts as a special cycle only when dcN=0, mioN=0 and wrN=1 on that same edge. Any other qualifier combination produces no readyN pulse, no event and no error.
- R3: A special cycle sampled at rising edge k drives readyN low from edge k+1 until edge k+2, for exactly one clock. At all other times readyN stays high.
- R4: evtValid is high in exactly the clock in which readyN is low, and is 0 otherwise. evtCode is 0 whenever evtValid is 0.
- R5: When addr[31:5] is zero and addr[4:3]=00b, the event code is set by beN. FEh gives 1 (shutdown), FDh gives 2 (cache flush), FBh gives 3 (halt), F7h gives 4 (writeback), EFh gives 5 (flush acknowledge) and BFh gives 6 (power-management stop grant).
- R6: beN=FBh gives code 7 (stop grant) when addr[4:3]=10b, and code 3 (halt) when addr[4:3]=00b.
- R7: A special cycle whose beN and addr[4:3] pair is not listed in R5 or R6 sets evtErr for the acknowledge clock, reports code 0, and still pulses readyN as in R3.
- R8: A special cycle with any of addr[31:5] nonzero sets evtErr, reports code 0, and still pulses readyN, whatever beN holds.
- R9: A strobe sampled at edge k+1 or edge k+2, after a special cycle accepted at edge k, is ignored. It causes no further readyN pulse and does not change the reported code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adsN | input | 1 | Address strobe, active low |
| dcN | input | 1 | Data/code qualifier (0 = code) |
| mioN | input | 1 | Memory/IO qualifier (0 = IO) |
| wrN | input | 1 | Write/read qualifier (1 = write) |
| beN | input | 8 | Byte enables, active low |
| addr | input | ADDR_MSB-2 | Address bits ADDR_MSB down to 3 |
| readyN | output | 1 | Cycle ready, active low |
| evtValid | output | 1 | One-clock event strobe |
| evtCode | output | 3 | Decoded event code |
| evtErr | output | 1 | One-clock flag for a malformed special cycle |

## Verification
The assertions assume that every qualifier and strobe is stable and known at each rising edge. The bench meets this by changing all inputs only on falling edges. The assertions also rely on the processor never issuing a second special cycle before the first has been readied. The bench breaks that rule on purpose only in the R9 scenario, and in that scenario it keeps the strobe low across the two busy edges. The checker's rule that a ready pulse needs a special strobe two edges earlier still holds there, because the first strobe was special.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam int BE_W   = 8;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    EV_NONE      = 3'd0,
    EV_SHUTDOWN  = 3'd1,
    EV_FLUSH     = 3'd2,
    EV_HALT      = 3'd3,
    EV_WRBACK    = 3'd4,
    EV_FLUSHACK  = 3'd5,
    EV_PMSTOPGNT = 3'd6,
    EV_STOPGNT   = 3'd7
  } evtCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch bus fields of an accepted special cycle
    logic present;   // drive ready low and publish the event this clock
  } ctrlStrobe_t;

endpackage

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        adsN,
  input  logic        dcN,
  input  logic        mioN,
  input  logic        wrN,
  output ctrlStrobe_t strobe
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACK  = 2'd2
  } state_e;

  state_e state;
  state_e stateNext;
  logic   isSpecial;

  // code, IO, write: the special-cycle qualifier set
  assign isSpecial = !adsN && !dcN && !mioN && wrN;

  always_comb begin
    stateNext      = state;
    strobe.capture = 1'b0;
    strobe.present = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (isSpecial) begin
          strobe.capture = 1'b1;
          stateNext      = ST_PEND;
        end
      end
      ST_PEND: begin
        strobe.present = 1'b1;
        stateNext      = ST_ACK;
      end
      ST_ACK: begin
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

endmodule

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int ADDR_MSB = 31
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobe_t           strobe,
  input  logic [BE_W-1:0]       beN,
  input  logic [ADDR_MSB:3]     addr,
  output logic                  readyN,
  output logic                  evtValid,
  output logic [CODE_W-1:0]     evtCode,
  output logic                  evtErr
);

  logic [BE_W-1:0]   beQ;
  logic [ADDR_MSB:3] addrQ;
  logic              upperZero;
  logic [1:0]        lowSel;
  evtCode_e          decCode;
  logic              decErr;

  always_ff @(posedge clk) begin
    if (rst) begin
      beQ   <= '1;
      addrQ <= '0;
    end else if (strobe.capture) begin
      beQ   <= beN;
      addrQ <= addr;
    end
  end

  assign upperZero = ~|addrQ[ADDR_MSB:5];
  assign lowSel    = addrQ[4:3];

  always_comb begin
    decCode = EV_NONE;
    decErr  = 1'b0;
    if (!upperZero) begin
      decErr = 1'b1;
    end else begin
      unique case ({beQ, lowSel})
        {8'hFE, 2'b00}: decCode = EV_SHUTDOWN;
        {8'hFD, 2'b00}: decCode = EV_FLUSH;
        {8'hFB, 2'b00}: decCode = EV_HALT;
        {8'hF7, 2'b00}: decCode = EV_WRBACK;
        {8'hEF, 2'b00}: decCode = EV_FLUSHACK;
        {8'hBF, 2'b00}: decCode = EV_PMSTOPGNT;
        {8'hFB, 2'b10}: decCode = EV_STOPGNT;
        default:        decErr  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !strobe.present) begin
      readyN   <= 1'b1;
      evtValid <= 1'b0;
      evtCode  <= '0;
      evtErr   <= 1'b0;
    end else begin
      readyN   <= 1'b0;
      evtValid <= 1'b1;
      evtCode  <= decCode;
      evtErr   <= decErr;
    end
  end

endmodule

// File: rtl/sbc_responder.sv
module sbc_responder
  import sbc_pkg::*;
#(
  parameter int ADDR_MSB = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adsN,
  input  logic              dcN,
  input  logic              mioN,
  input  logic              wrN,
  input  logic [7:0]        beN,
  input  logic [ADDR_MSB:3] addr,
  output logic              readyN,
  output logic              evtValid,
  output logic [2:0]        evtCode,
  output logic              evtErr
);

  ctrlStrobe_t strobe;

  sbc_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .adsN   (adsN),
    .dcN    (dcN),
    .mioN   (mioN),
    .wrN    (wrN),
    .strobe (strobe)
  );

  sbc_datapath #(.ADDR_MSB(ADDR_MSB)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .beN      (beN),
    .addr     (addr),
    .readyN   (readyN),
    .evtValid (evtValid),
    .evtCode  (evtCode),
    .evtErr   (evtErr)
  );

endmodule

// File: rtl/sbc_responder_chk.sv
module sbc_responder_chk (
  input logic       clk,
  input logic       rst,
  input logic       adsN,
  input logic       dcN,
  input logic       mioN,
  input logic       wrN,
  input logic       readyN,
  input logic       evtValid,
  input logic [2:0] evtCode,
  input logic       evtErr
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (readyN && !evtValid && !evtErr && evtCode == 3'd0));

  // R3
  ready_single_chk: assert property (@(posedge clk) disable iff (rst)
    !readyN |=> readyN);

  // R2
  ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !readyN |-> $past(!adsN && !dcN && !mioN && wrN, 2));

  // R4
  valid_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
    evtValid == !readyN);

  // R4
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    !evtValid |-> (evtCode == 3'd0 && !evtErr));

  // R7
  err_code_chk: assert property (@(posedge clk) disable iff (rst)
    evtErr |-> (evtCode == 3'd0 && !readyN));

  // R5
  valid_meaning_chk: assert property (@(posedge clk) disable iff (rst)
    evtValid |-> (evtErr || evtCode != 3'd0));

endmodule

bind sbc_responder sbc_responder_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .adsN     (adsN),
  .dcN      (dcN),
  .mioN     (mioN),
  .wrN      (wrN),
  .readyN   (readyN),
  .evtValid (evtValid),
  .evtCode  (evtCode),
  .evtErr   (evtErr)
);

// File: tb/sbc_responder_tb_top.sv
`timescale 1ns/1ps
module sbc_responder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adsN = 1'b1;
  logic        dcN = 1'b1;
  logic        mioN = 1'b1;
  logic        wrN = 1'b0;
  logic [7:0]  beN = 8'hFF;
  logic [31:3] addr = '0;
  logic        readyN;
  logic        evtValid;
  logic [2:0]  evtCode;
  logic        evtErr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sbc_responder dut_i (
    .clk(clk), .rst(rst), .adsN(adsN), .dcN(dcN), .mioN(mioN), .wrN(wrN),
    .beN(beN), .addr(addr), .readyN(readyN), .evtValid(evtValid),
    .evtCode(evtCode), .evtErr(evtErr)
  );

  task automatic check(string tag, int actual, int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic checkIdle(string tag);
    check(tag, {readyN, evtValid, evtErr, evtCode}, {1'b1, 1'b0, 1'b0, 3'd0});
  endtask

  // drive one cycle for one edge, then check the ack window
  task automatic busCycle(logic d, logic m, logic w, logic [7:0] be, logic [31:0] a,
                          bit expAck, int expCode, bit expErr, string tag);
    @(negedge clk);
    adsN = 1'b0; dcN = d; mioN = m; wrN = w; beN = be; addr = a[31:3];
    @(negedge clk);                 // edge k sampled
    adsN = 1'b1; beN = 8'hFF; addr = '0;
    checkIdle({tag, " pending"});
    @(negedge clk);                 // after edge k+1
    if (expAck)
      check(tag, {readyN, evtValid, evtErr, evtCode},
            {1'b0, 1'b1, expErr, 3'(expCode)});
    else
      checkIdle(tag);
    @(negedge clk);                 // after edge k+2
    checkIdle({tag, " after"});
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    checkIdle("R1 after release");
  endtask

  task automatic testQualifiers();
    busCycle(1'b1, 1'b0, 1'b1, 8'hFB, 32'h0, 1'b0, 0, 1'b0, "R2 data");
    busCycle(1'b0, 1'b1, 1'b1, 8'hFB, 32'h0, 1'b0, 0, 1'b0, "R2 memory");
    busCycle(1'b0, 1'b0, 1'b0, 8'hFB, 32'h0, 1'b0, 0, 1'b0, "R2 read");
  endtask

  task automatic testTable();
    busCycle(1'b0, 1'b0, 1'b1, 8'hFE, 32'h0, 1'b1, 1, 1'b0, "R5 shutdown R3");
    busCycle(1'b0, 1'b0, 1'b1, 8'hFD, 32'h0, 1'b1, 2, 1'b0, "R5 flush");
    busCycle(1'b0, 1'b0, 1'b1, 8'hF7, 32'h0, 1'b1, 4, 1'b0, "R5 writeback");
    busCycle(1'b0, 1'b0, 1'b1, 8'hEF, 32'h0, 1'b1, 5, 1'b0, "R5 flushack");
    busCycle(1'b0, 1'b0, 1'b1, 8'hBF, 32'h0, 1'b1, 6, 1'b0, "R5 pm stopgrant");
  endtask

  task automatic testAlias();
    busCycle(1'b0, 1'b0, 1'b1, 8'hFB, 32'h0,  1'b1, 3, 1'b0, "R6 halt");
    busCycle(1'b0, 1'b0, 1'b1, 8'hFB, 32'h10, 1'b1, 7, 1'b0, "R6 stopgrant");
  endtask

  task automatic testErrors();
    busCycle(1'b0, 1'b0, 1'b1, 8'hFB, 32'h08, 1'b1, 0, 1'b1, "R7 fb a01");
    busCycle(1'b0, 1'b0, 1'b1, 8'hFE, 32'h10, 1'b1, 0, 1'b1, "R7 fe a10");
    busCycle(1'b0, 1'b0, 1'b1, 8'h00, 32'h0,  1'b1, 0, 1'b1, "R7 be 00");
    busCycle(1'b0, 1'b0, 1'b1, 8'hFB, 32'h20, 1'b1, 0, 1'b1, "R8 a5");
    busCycle(1'b0, 1'b0, 1'b1, 8'hFE, 32'h8000_0000, 1'b1, 0, 1'b1, "R8 a31");
  endtask

  task automatic testBusy();
    @(negedge clk);
    adsN = 1'b0; dcN = 1'b0; mioN = 1'b0; wrN = 1'b1; beN = 8'hFE; addr = '0;
    @(negedge clk);                 // edge k: shutdown accepted
    beN = 8'hFD;                    // strobe held low at k+1 and k+2
    @(negedge clk);
    check("R9 first ack", {readyN, evtCode}, {1'b0, 3'd1});
    @(negedge clk);
    adsN = 1'b1; beN = 8'hFF;
    checkIdle("R9 no ack at k+2");
    @(negedge clk);
    checkIdle("R9 ignored strobe k+1");
    @(negedge clk);
    checkIdle("R9 ignored strobe k+2");
  endtask

  initial begin
    testReset();
    testQualifiers();
    testTable();
    testAlias();
    testErrors();
    testBusy();
    busCycle(1'b0, 1'b0, 1'b1, 8'hFB, 32'h0, 1'b1, 3, 1'b0, "R3 back to back");
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule